// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose pins behind a 16-bit register bus. Software chooses, per pin, whether the pin drives or receives. It also sets the driven value and whether the pin is handed to an alternate function. Each output control goes straight to the pad logic as a registered signal. Incoming pin levels pass through a synchronizer, and software can read them back through a read-only register.

Each pin can also raise an interrupt. A trigger-type bit picks edge or level detection. An edge-polarity register then chooses rising or falling, and a level-polarity register chooses active-high or active-low. A pin that meets its condition while its block bit is clear sets a sticky status bit. The bank interrupt line is high whenever any status bit is set. Software clears status bits by writing zeros to the status register. To get both-edge behaviour, software flips a pin's edge-polarity bit after each event. Changing that bit never creates an event on its own.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the block register reads 0xFFFF, every other writable register reads 0, and `bank_irq`, `pin_oe`, `pin_out` and `alt_sel` are 0.
- R2: The register map uses word indices on `reg_addr`: 0 direction, 1 output data, 2 pin level, 3 alternate select, 4 block, 5 trigger type, 6 edge polarity, 7 level polarity, 8 status. Writable registers read back the value written. Indices 9 to 15 ignore writes and read 0.
- R3: The direction, output-data and alternate-select registers drive `pin_oe` (1 = output, 0 = input), `pin_out` and `alt_sel` bit for bit, one cycle after the write.
- R4: The pin-level register returns `pin_in` as it stood two clock edges earlier and ignores writes.
- R5: A block bit of 1 keeps that pin from ever setting its status bit. A 0 lets the pin through.
- R6: When the trigger-type bit is 1, the pin uses edge detection. Edge-polarity 1 sets status on a rising edge of the synchronized input, and 0 sets it on a falling edge. Status sets on the third clock edge after the pin changes. An edge of the other direction does nothing.
- R7: When the trigger-type bit is 0, the pin uses level detection. Level-polarity 1 sets status while the synchronized input is high, and 0 sets it while the input is low.
- R8: Status bits are sticky. A write to the status register clears every bit written as 0 and leaves every bit written as 1 unchanged. A write can never set a bit.
- R9: A level-mode status bit cleared by a write stays 0 for that cycle. If its level is still active, it sets again on the next clock edge.
- R10: `bank_irq` is 1 exactly when at least one status bit is 1.
- R11: Writing the edge-polarity register at any time creates no status event by itself. Flipping the bit after each event gives both-edge detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register word index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data to pads |
| pin_oe | output | 16 | Output enable to pads (1 = drive) |
| alt_sel | output | 16 | Alternate-function select per pin |
| bank_irq | output | 1 | Bank interrupt, OR of status |

## Verification
Assertions run on every cycle and check four things:
- a blocked pin never sets a status bit;
- an edge-mode bit sets only after a real transition of the synchronized input;
- status bits fall only on a status write;
- a cleared level bit stays 0 during its clear cycle.

Other behaviour needs the bench's scenarios to show it:
- the exact latency from pin change to status;
- the re-set of a level bit one edge after its clear;
- selective clearing by data pattern;
- the absence of events when the edge polarity flips;
- the register map decode, including reads of unused indices.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   typedef enum logic [3:0] {
      RG_DIR    = 4'd0,
      RG_OUT    = 4'd1,
      RG_LEVEL  = 4'd2,
      RG_ALT    = 4'd3,
      RG_BLOCK  = 4'd4,
      RG_TRIG   = 4'd5,
      RG_EPOL   = 4'd6,
      RG_LPOL   = 4'd7,
      RG_STATUS = 4'd8
   } reg_idx_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int PINS = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] lvl,
   input  logic [PINS-1:0] trig,
   input  logic [PINS-1:0] epol,
   input  logic [PINS-1:0] lpol,
   input  logic [PINS-1:0] blk,
   input  logic            clr_wr,
   input  logic [PINS-1:0] clr_data,
   output logic [PINS-1:0] status
);
   logic [PINS-1:0] prev, cond, hit, keep, status_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      assign cond[i] = trig[i] ? (epol[i] ? (lvl[i] & ~prev[i]) : (~lvl[i] & prev[i]))
                               : ~(lvl[i] ^ lpol[i]);
   end

   assign hit        = cond & ~blk;
   assign keep       = clr_wr ? clr_data : '1;
   // a level bit being cleared ignores its condition for that one cycle
   assign status_nxt = (status & keep) | (hit & (trig | keep));

   always_ff @(posedge clk) begin
      if (!rst_n) status <= '0;
      else        status <= status_nxt;
   end

   assert_blocked_no_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~$past(status) & $past(blk)) == '0);

   assert_edge_needs_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~$past(status) & $past(trig) & ~($past(lvl) ^ $past(prev))) == '0);

   assert_sticky_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr_wr) |-> ((~status & $past(status)) == '0));

   assert_level_clear_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_wr) |-> ((status & ~$past(clr_data) & ~$past(trig)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int PINS        = 16,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [PINS-1:0]   reg_wdata,
   output logic [PINS-1:0]   reg_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic [PINS-1:0]   alt_sel,
   output logic              bank_irq
);
   if (ADDR_W < 4) begin : g_bad_addr
      $error("gpio_irq_bank: ADDR_W must cover the status index");
   end
   if (PINS < 1) begin : g_bad_pins
      $error("gpio_irq_bank: PINS must be positive");
   end

   localparam logic [PINS-1:0] BLOCK_RST = '1;

   logic [PINS-1:0] dir_q, out_q, alt_q, blk_q, trig_q, epol_q, lpol_q;
   logic [PINS-1:0] lvl_sync, status;
   logic            wr_dir, wr_out, wr_alt, wr_blk, wr_trig, wr_epol, wr_lpol, wr_stat;

   assign wr_dir  = reg_wr && (reg_addr == ADDR_W'(RG_DIR));
   assign wr_out  = reg_wr && (reg_addr == ADDR_W'(RG_OUT));
   assign wr_alt  = reg_wr && (reg_addr == ADDR_W'(RG_ALT));
   assign wr_blk  = reg_wr && (reg_addr == ADDR_W'(RG_BLOCK));
   assign wr_trig = reg_wr && (reg_addr == ADDR_W'(RG_TRIG));
   assign wr_epol = reg_wr && (reg_addr == ADDR_W'(RG_EPOL));
   assign wr_lpol = reg_wr && (reg_addr == ADDR_W'(RG_LPOL));
   assign wr_stat = reg_wr && (reg_addr == ADDR_W'(RG_STATUS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         alt_q  <= '0;
         blk_q  <= BLOCK_RST;
         trig_q <= '0;
         epol_q <= '0;
         lpol_q <= '0;
      end else begin
         if (wr_dir)  dir_q  <= reg_wdata;
         if (wr_out)  out_q  <= reg_wdata;
         if (wr_alt)  alt_q  <= reg_wdata;
         if (wr_blk)  blk_q  <= reg_wdata;
         if (wr_trig) trig_q <= reg_wdata;
         if (wr_epol) epol_q <= reg_wdata;
         if (wr_lpol) lpol_q <= reg_wdata;
      end
   end

   gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (lvl_sync)
   );

   gpio_irq_detect #(.PINS(PINS)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_sync),
      .trig     (trig_q),
      .epol     (epol_q),
      .lpol     (lpol_q),
      .blk      (blk_q),
      .clr_wr   (wr_stat),
      .clr_data (reg_wdata),
      .status   (status)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(RG_DIR):    reg_rdata = dir_q;
         ADDR_W'(RG_OUT):    reg_rdata = out_q;
         ADDR_W'(RG_LEVEL):  reg_rdata = lvl_sync;
         ADDR_W'(RG_ALT):    reg_rdata = alt_q;
         ADDR_W'(RG_BLOCK):  reg_rdata = blk_q;
         ADDR_W'(RG_TRIG):   reg_rdata = trig_q;
         ADDR_W'(RG_EPOL):   reg_rdata = epol_q;
         ADDR_W'(RG_LPOL):   reg_rdata = lpol_q;
         ADDR_W'(RG_STATUS): reg_rdata = status;
         default:            reg_rdata = '0;
      endcase
   end

   assign pin_oe   = dir_q;
   assign pin_out  = out_q;
   assign alt_sel  = alt_q;
   assign bank_irq = |status;

   assert_irq_drops_after_full_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_stat) && ($past(reg_wdata) == '0) && ($past(blk_q) == BLOCK_RST)) |-> !bank_irq);
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;
   // {index[3:0], write data[15:0], expected readback[15:0]}
   localparam logic [35:0] VEC [NV] = '{
      {4'h0, 16'hA55A, 16'hA55A},
      {4'h1, 16'h1234, 16'h1234},
      {4'h2, 16'hFFFF, 16'h0000},
      {4'h3, 16'h0F0F, 16'h0F0F},
      {4'h5, 16'h00FF, 16'h00FF},
      {4'h6, 16'hC3C3, 16'hC3C3},
      {4'h7, 16'h3C3C, 16'h3C3C},
      {4'h8, 16'hFFFF, 16'h0000},
      {4'h9, 16'hFFFF, 16'h0000},
      {4'hF, 16'hBEEF, 16'h0000},
      {4'h4, 16'hFFFE, 16'hFFFE}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe, alt_sel;
   logic        bank_irq;

   int checks = 0;
   int failures = 0;
   logic [15:0] rd;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_bank dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel), .bank_irq(bank_irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic edges(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      rd_reg(4'h4, rd); chk("R1 block reset", rd, 16'hFFFF);
      rd_reg(4'h0, rd); chk("R1 dir reset", rd, 16'h0000);
      rd_reg(4'h8, rd); chk("R1 status reset", rd, 16'h0000);
      chk("R1 irq reset", {15'd0, bank_irq}, 16'h0000);
      chk("R1 oe reset", pin_oe, 16'h0000);

      // R2 register map walk
      for (int v = 0; v < NV; v++) begin
         wr(VEC[v][35:32], VEC[v][31:16]);
         rd_reg(VEC[v][35:32], rd);
         chk($sformatf("R2 vector %0d", v), rd, VEC[v][15:0]);
      end
      // R3 pad outputs follow registers
      chk("R3 pin_oe", pin_oe, 16'hA55A);
      chk("R3 pin_out", pin_out, 16'h1234);
      chk("R3 alt_sel", alt_sel, 16'h0F0F);

      // setup: bit0 edge rising, bit1 level high, bit2 level low
      wr(4'h4, 16'hFFFF);
      wr(4'h5, 16'h0001);
      wr(4'h6, 16'h0001);
      wr(4'h7, 16'h0002);
      wr(4'h8, 16'h0000);

      // R5 blocked pin does not set
      @(negedge clk) pin_in[0] = 1'b1;
      edges(4);
      rd_reg(4'h8, rd); chk("R5 blocked edge", rd, 16'h0000);
      chk("R5 irq stays low", {15'd0, bank_irq}, 16'h0000);
      @(negedge clk) pin_in[0] = 1'b0;
      edges(4);
      wr(4'h4, 16'hFFFE);

      // R6 rising edge latency
      @(negedge clk) pin_in[0] = 1'b1;
      edges(2);
      rd_reg(4'h8, rd); chk("R6 not yet", rd, 16'h0000);
      edges(1);
      rd_reg(4'h8, rd); chk("R6 rising sets", rd, 16'h0001);
      chk("R10 irq high", {15'd0, bank_irq}, 16'h0001);
      wr(4'h8, 16'h0000);
      rd_reg(4'h8, rd); chk("R8 zero clears", rd, 16'h0000);
      chk("R10 irq low", {15'd0, bank_irq}, 16'h0000);
      @(negedge clk) pin_in[0] = 1'b0;
      edges(4);
      rd_reg(4'h8, rd); chk("R6 falling ignored", rd, 16'h0000);

      // R11 polarity flip has no side effect; falling mode
      wr(4'h6, 16'h0000);
      edges(3);
      rd_reg(4'h8, rd); chk("R11 flip quiet", rd, 16'h0000);
      @(negedge clk) pin_in[0] = 1'b1;
      edges(4);
      rd_reg(4'h8, rd); chk("R6 rising ignored", rd, 16'h0000);
      @(negedge clk) pin_in[0] = 1'b0;
      edges(4);
      rd_reg(4'h8, rd); chk("R6 falling sets", rd, 16'h0001);
      wr(4'h8, 16'h0000);
      wr(4'h6, 16'h0001);
      edges(3);
      rd_reg(4'h8, rd); chk("R11 flip back quiet", rd, 16'h0000);

      // R7 level high on bit1, R9 re-set after clear
      wr(4'h4, 16'hFFFC);
      edges(3);
      rd_reg(4'h8, rd); chk("R7 high idle", rd, 16'h0000);
      @(negedge clk) pin_in[1] = 1'b1;
      edges(3);
      rd_reg(4'h8, rd); chk("R7 level high sets", rd, 16'h0002);
      wr(4'h8, 16'hFFFF);
      rd_reg(4'h8, rd); chk("R8 ones keep", rd, 16'h0002);
      wr(4'h8, 16'h0000);
      rd_reg(4'h8, rd); chk("R9 cleared cycle", rd, 16'h0000);
      edges(1);
      rd_reg(4'h8, rd); chk("R9 sets again", rd, 16'h0002);
      @(negedge clk) pin_in[1] = 1'b0;
      edges(3);
      wr(4'h8, 16'h0000);
      edges(3);
      rd_reg(4'h8, rd); chk("R7 inactive stays clear", rd, 16'h0000);

      // R7 level low on bit2
      wr(4'h4, 16'hFFF8);
      edges(1);
      rd_reg(4'h8, rd); chk("R7 level low sets", rd, 16'h0004);
      @(negedge clk) pin_in[2] = 1'b1;
      edges(3);
      wr(4'h8, 16'h0000);
      edges(3);
      rd_reg(4'h8, rd); chk("R7 low released", rd, 16'h0000);

      // R8 selective clear
      @(negedge clk) begin pin_in[0] = 1'b1; pin_in[1] = 1'b1; end
      edges(4);
      rd_reg(4'h8, rd); chk("R8 two set", rd, 16'h0003);
      wr(4'h8, 16'h0002);
      rd_reg(4'h8, rd); chk("R8 selective", rd, 16'h0002);

      // R4 pin level latency and read-only
      @(negedge clk) pin_in = 16'hA5A7;
      edges(1);
      rd_reg(4'h2, rd); chk("R4 one edge", rd, 16'h0007);
      edges(1);
      rd_reg(4'h2, rd); chk("R4 two edges", rd, 16'hA5A7);
      wr(4'h2, 16'h0000);
      rd_reg(4'h2, rd); chk("R4 write ignored", rd, 16'hA5A7);

      // R10 full clear with all pins blocked
      wr(4'h4, 16'hFFFF);
      wr(4'h8, 16'h0000);
      edges(3);
      chk("R10 irq after clear", {15'd0, bank_irq}, 16'h0000);

      finish_run();
   end
endmodule